// File: doc/BRIEF.md
# Pipelined Decimal Floating-Point Adder

This block adds two floating-point numbers whose significands are held as four packed BCD digits. Each exponent is a signed power of ten. A number carries a sign bit, an integer significand from 0 to 9999 and a two's-complement exponent. Its value is (-1)^sign × significand × 10^exponent.

The work runs in three register stages, always in the same order. The first stage picks the operand with the larger exponent and shifts the other significand right by whole digits. The second stage either adds the two magnitudes or subtracts the smaller from the larger. The third stage restores a nonzero leading digit and corrects the exponent. A valid bit moves through the stages with the data. A new operation can enter on every clock, and every result leaves exactly three clocks after its operands. Digits pushed past the four-digit width are dropped, so the result is truncated.

Top module: `dfp_adder`

## Requirements
- R1: After reset, and until an accepted operation has passed through all three stages, out_valid is 0.
- R2: An operation presented with in_valid=1 at a rising edge appears with out_valid=1 after exactly the third rising edge counted from that one. Operations presented on consecutive edges come out on consecutive cycles, in order.
- R3: Operand and result format. The sign bit is 1 for negative. The significand is four BCD digits, with bits [15:12] holding the most significant digit. The exponent is an 8-bit two's-complement power of ten. Every digit of a valid result lies in 0..9.
- R4: The operand with the smaller exponent has its significand shifted right by one digit for each unit of exponent difference, and the digits shifted out are discarded. When the difference is 4 or more, that operand contributes nothing.
- R5: When the signs are equal, the aligned magnitudes are added. If the sum exceeds four digits, it is shifted right one digit, the lowest digit is dropped and the exponent rises by one.
- R6: When the signs differ, the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the larger magnitude.
- R7: A nonzero result whose leading digit is zero is shifted left one digit at a time until its leading digit is nonzero. The exponent falls by one for each shift.
- R8: A result whose significand is all zero is delivered as sign 0, significand 0000 and exponent 0.
- R9: 1234×10^-4 plus -6543×10^-5 yields 5800×10^-5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_mant | input | 16 | Four-digit BCD significand of A |
| a_exp | input | 8 | Two's-complement exponent of A |
| b_sign | input | 1 | Sign of operand B |
| b_mant | input | 16 | Four-digit BCD significand of B |
| b_exp | input | 8 | Two's-complement exponent of B |
| out_valid | output | 1 | A result is present |
| out_sign | output | 1 | Sign of the result |
| out_mant | output | 16 | Normalized BCD significand of the result |
| out_exp | output | 8 | Two's-complement exponent of the result |

## Verification
Each result is due after the third rising edge that follows the edge capturing its operands. The single-operation tasks drive the inputs on a falling edge. They confirm that out_valid is still low half a cycle after the second edge, then read the result at the falling edge after the third. The streaming test drives a new operation at every falling edge. It compares the output seen at falling edge k against operation k-3, with expected values computed by integer arithmetic that follows the requirements.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

    parameter int NDIG = 4;              // significand digits
    parameter int EXPW = 8;              // exponent width
    localparam int MW  = 4 * NDIG;       // significand bits

    typedef struct packed {
        logic                   sgn;
        logic [MW-1:0]          mant;
        logic signed [EXPW-1:0] ex;
    } dfp_t;

    typedef struct packed {
        logic                   vld;
        logic                   big_s;
        logic                   sml_s;
        logic [MW-1:0]          big_m;
        logic [MW-1:0]          sml_m;
        logic signed [EXPW-1:0] ex;
    } aligned_t;

    typedef struct packed {
        logic                   vld;
        logic                   sgn;
        logic                   cy;
        logic [MW-1:0]          m;
        logic signed [EXPW-1:0] ex;
    } summed_t;

    // digit-serial BCD addition, returns {carry, sum}
    function automatic logic [MW:0] bcd_add(input logic [MW-1:0] x, input logic [MW-1:0] y);
        logic [MW-1:0] r;
        logic          c;
        logic [4:0]    t;
        r = '0;
        c = 1'b0;
        for (int d = 0; d < NDIG; d++) begin
            t = {1'b0, x[4*d +: 4]} + {1'b0, y[4*d +: 4]} + {4'd0, c};
            if (t > 5'd9) begin
                t = t - 5'd10;
                c = 1'b1;
            end else begin
                c = 1'b0;
            end
            r[4*d +: 4] = t[3:0];
        end
        return {c, r};
    endfunction

    // BCD subtraction x - y, caller guarantees x >= y
    function automatic logic [MW-1:0] bcd_sub(input logic [MW-1:0] x, input logic [MW-1:0] y);
        logic [MW-1:0] r;
        logic          b;
        logic [4:0]    t;
        r = '0;
        b = 1'b0;
        for (int d = 0; d < NDIG; d++) begin
            t = {1'b0, x[4*d +: 4]} - {1'b0, y[4*d +: 4]} - {4'd0, b};
            if (t[4]) begin
                t = t + 5'd10;
                b = 1'b1;
            end else begin
                b = 1'b0;
            end
            r[4*d +: 4] = t[3:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/dfp_align_stage.sv
module dfp_align_stage
    import dfp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vld_i,
    input  dfp_t     a_i,
    input  dfp_t     b_i,
    output aligned_t q_o
);

    dfp_t            big, sml;
    logic [EXPW:0]   diff;
    logic [MW-1:0]   shifted;
    aligned_t        nxt;

    always_comb begin
        if (a_i.ex >= b_i.ex) begin
            big = a_i;
            sml = b_i;
        end else begin
            big = b_i;
            sml = a_i;
        end
        diff = {big.ex[EXPW-1], big.ex} - {sml.ex[EXPW-1], sml.ex};
        shifted = '0;
        for (int i = 0; i < NDIG; i++) begin
            if (diff == (EXPW+1)'(i)) shifted = sml.mant >> (4 * i);
        end
        nxt.vld   = vld_i;
        nxt.big_s = big.sgn;
        nxt.sml_s = sml.sgn;
        nxt.big_m = big.mant;
        nxt.sml_m = shifted;
        nxt.ex    = big.ex;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

endmodule

// File: rtl/dfp_sum_stage.sv
module dfp_sum_stage
    import dfp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  aligned_t d_i,
    output summed_t  q_o
);

    summed_t       nxt;
    logic [MW:0]   addv;
    logic          big_wins;

    always_comb begin
        addv     = bcd_add(d_i.big_m, d_i.sml_m);
        big_wins = (d_i.big_m >= d_i.sml_m);
        nxt.vld  = d_i.vld;
        nxt.ex   = d_i.ex;
        if (d_i.big_s == d_i.sml_s) begin
            nxt.sgn = d_i.big_s;
            nxt.cy  = addv[MW];
            nxt.m   = addv[MW-1:0];
        end else if (big_wins) begin
            nxt.sgn = d_i.big_s;
            nxt.cy  = 1'b0;
            nxt.m   = bcd_sub(d_i.big_m, d_i.sml_m);
        end else begin
            nxt.sgn = d_i.sml_s;
            nxt.cy  = 1'b0;
            nxt.m   = bcd_sub(d_i.sml_m, d_i.big_m);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

endmodule

// File: rtl/dfp_norm_stage.sv
module dfp_norm_stage
    import dfp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  summed_t d_i,
    output logic    vld_o,
    output dfp_t    q_o
);

    dfp_t nxt;
    int   lz;
    logic found;

    always_comb begin
        lz    = 0;
        found = 1'b0;
        for (int k = NDIG - 1; k >= 0; k--) begin
            if (!found && d_i.m[4*k +: 4] != 4'd0) begin
                found = 1'b1;
                lz    = NDIG - 1 - k;
            end
        end
        if (d_i.cy) begin
            nxt.sgn  = d_i.sgn;
            nxt.mant = {4'd1, d_i.m[MW-1:4]};
            nxt.ex   = d_i.ex + EXPW'(1);
        end else if (!found) begin
            nxt = '0;
        end else begin
            nxt.sgn  = d_i.sgn;
            nxt.mant = d_i.m << (4 * lz);
            nxt.ex   = d_i.ex - EXPW'(lz);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= d_i.vld;
            q_o   <= nxt;
        end
    end

endmodule

// File: rtl/dfp_adder.sv
module dfp_adder
    import dfp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            a_sign,
    input  logic [MW-1:0]   a_mant,
    input  logic [EXPW-1:0] a_exp,
    input  logic            b_sign,
    input  logic [MW-1:0]   b_mant,
    input  logic [EXPW-1:0] b_exp,
    output logic            out_valid,
    output logic            out_sign,
    output logic [MW-1:0]   out_mant,
    output logic [EXPW-1:0] out_exp
);

    dfp_t     op_a, op_b, res;
    aligned_t s1;
    summed_t  s2;

    assign op_a = '{sgn: a_sign, mant: a_mant, ex: a_exp};
    assign op_b = '{sgn: b_sign, mant: b_mant, ex: b_exp};

    dfp_align_stage u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .a_i   (op_a),
        .b_i   (op_b),
        .q_o   (s1)
    );

    dfp_sum_stage u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (s1),
        .q_o   (s2)
    );

    dfp_norm_stage u_norm (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (s2),
        .vld_o (out_valid),
        .q_o   (res)
    );

    assign out_sign = res.sgn;
    assign out_mant = res.mant;
    assign out_exp  = res.ex;

endmodule

// File: rtl/dfp_adder_chk.sv
module dfp_adder_chk
    import dfp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            a_sign,
    input  logic [MW-1:0]   a_mant,
    input  logic [EXPW-1:0] a_exp,
    input  logic            b_sign,
    input  logic [MW-1:0]   b_mant,
    input  logic [EXPW-1:0] b_exp,
    input  logic            out_valid,
    input  logic            out_sign,
    input  logic [MW-1:0]   out_mant,
    input  logic [EXPW-1:0] out_exp
);

    logic [2:0] vhist;
    logic       digits_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[1:0], in_valid};
    end

    always_comb begin
        digits_ok = 1'b1;
        for (int d = 0; d < NDIG; d++) begin
            if (out_mant[4*d +: 4] > 4'd9) digits_ok = 1'b0;
        end
    end

    // R2: valid emerges exactly three edges after acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[2]);

    // R3: only legal BCD digits on a valid result
    a_r3_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> digits_ok);

    // R7: nonzero results carry a nonzero leading digit
    a_r7_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mant != '0) |-> out_mant[MW-1:MW-4] != 4'd0);

    // R8: zero is always positive with exponent zero
    a_r8_clean_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mant == '0) |-> (!out_sign && out_exp == '0));

endmodule

bind dfp_adder dfp_adder_chk u_chk (.*);

// File: tb/sim_dfp_adder.sv
module sim_dfp_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [15:0] a_mant = '0, b_mant = '0;
    logic [7:0]  a_exp = '0, b_exp = '0;
    logic        out_valid, out_sign;
    logic [15:0] out_mant;
    logic [7:0]  out_exp;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dfp_adder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_sign(a_sign), .a_mant(a_mant), .a_exp(a_exp),
        .b_sign(b_sign), .b_mant(b_mant), .b_exp(b_exp),
        .out_valid(out_valid), .out_sign(out_sign),
        .out_mant(out_mant), .out_exp(out_exp)
    );

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int d = 0; d < 4; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // expected result from the requirements, plain integer arithmetic
    task automatic model(input int as, input int am, input int ae,
                         input int bs, input int bm, input int be,
                         output int rs, output int rm, output int re);
        int bigv, smlv, sm, diff, tot, m, e;
        if (ae >= be) begin
            diff = ae - be; e = ae;
            bigv = as ? -am : am;
            sm = bm; smlv = bs;
        end else begin
            diff = be - ae; e = be;
            bigv = bs ? -bm : bm;
            sm = am; smlv = as;
        end
        if (diff >= 4) sm = 0;
        else for (int i = 0; i < diff; i++) sm = sm / 10;
        tot = bigv + (smlv ? -sm : sm);
        rs = (tot < 0) ? 1 : 0;
        m = (tot < 0) ? -tot : tot;
        if (m >= 10000) begin m = m / 10; e = e + 1; end
        if (m == 0) begin rs = 0; e = 0; end
        else while (m < 1000) begin m = m * 10; e = e - 1; end
        rm = m; re = e;
    endtask

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input int as, input int am, input int ae,
                         input int bs, input int bm, input int be);
        in_valid = 1'b1;
        a_sign = as[0]; a_mant = to_bcd(am); a_exp = ae[7:0];
        b_sign = bs[0]; b_mant = to_bcd(bm); b_exp = be[7:0];
    endtask

    task automatic check_out(input string req, input int es, input int em, input int ee);
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "out_sign", int'(out_sign), es);
        check(req, "out_mant", int'(out_mant), int'(to_bcd(em)));
        check(req, "out_exp", int'($signed(out_exp)), ee);
    endtask

    // one isolated operation with explicit expected values
    task automatic run_one(input string req,
                           input int as, input int am, input int ae,
                           input int bs, input int bm, input int be,
                           input int es, input int em, input int ee);
        @(negedge clk);
        drive(as, am, ae, bs, bm, be);
        @(negedge clk);                 // edge 1 has captured the operands
        in_valid = 1'b0;
        @(negedge clk);                 // after edge 2: not yet due (R2)
        check("R2", "early out_valid", int'(out_valid), 0);
        @(negedge clk);                 // after edge 3: result due
        check_out(req, es, em, ee);
        @(negedge clk);
        check("R2", "single-cycle out_valid", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        check("R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_example();
        run_one("R9", 0, 1234, -4, 1, 6543, -5, 0, 5800, -5);
    endtask

    task automatic t_align();
        run_one("R4", 0, 1234, 5, 1, 9999, 1, 0, 1234, 5);   // gap of 4
        run_one("R4", 0, 1234, 5, 0, 9999, 2, 0, 1243, 5);   // gap of 3
        run_one("R3", 1, 1500, -20, 1, 2500, -19, 1, 2650, -19);
    endtask

    task automatic t_carry();
        run_one("R5", 0, 9999, 0, 0, 9000, -3, 0, 1000, 1);
        run_one("R5", 1, 5555, -2, 1, 5555, -2, 1, 1111, -1);
    endtask

    task automatic t_subtract();
        run_one("R6", 0, 1000, 0, 1, 2000, 0, 1, 1000, 0);
        run_one("R6", 1, 3000, 2, 0, 5000, 1, 1, 2500, 2);
    endtask

    task automatic t_normalize();
        run_one("R7", 0, 1001, 0, 1, 1000, 0, 0, 1000, -3);
        run_one("R7", 1, 1234, -2, 0, 1230, -2, 1, 4000, -5);
    endtask

    task automatic t_zero();
        run_one("R8", 0, 5000, 2, 1, 5000, 2, 0, 0, 0);
        run_one("R8", 1, 7000, -7, 0, 7000, -7, 0, 0, 0);
    endtask

    // back-to-back stream, output k-3 checked at falling edge k
    task automatic t_stream();
        localparam int N = 16;
        int xs[N], xm[N], xe[N];
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check("R2", "stream out_valid", int'(out_valid), 1);
                check("R2", "stream out_sign", int'(out_sign), xs[i-3]);
                check("R2", "stream out_mant", int'(out_mant), int'(to_bcd(xm[i-3])));
                check("R2", "stream out_exp", int'($signed(out_exp)), xe[i-3]);
            end
            if (i < N) begin
                int as, am, ae, bs, bm, be;
                as = i % 2;
                bs = (i / 2) % 2;
                am = 1000 + (i * 1237) % 9000;
                bm = 1000 + (i * 2741 + 500) % 9000;
                ae = (i * 5) % 13 - 6;
                be = (i * 3) % 11 - 5;
                model(as, am, ae, bs, bm, be, xs[i], xm[i], xe[i]);
                drive(as, am, ae, bs, bm, be);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R2", "stream drained", int'(out_valid), 0);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_align();
        t_carry();
        t_subtract();
        t_normalize();
        t_zero();
        t_stream();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule